// File: doc/BRIEF.md
# Serially Programmed Sine Synthesis Core

This block is a numerically controlled oscillator with a slow serial programming port. A host shifts in a 24-bit tuning word one bit per strobe pulse while holding an enable line high. The tuning word sets the phase step taken on every synthesis clock. Once all 24 bits have arrived, the completed word crosses into the synthesis clock domain. It is then loaded into the step register on a single clock edge. The running phase is never cleared or disturbed by this load, so a change of frequency leaves no jump in the waveform.

The phase register wraps modulo 2^24. Its ten most significant bits address a sine table that stores one quarter of a period. The two top address bits select a mirror or a sign flip of that quarter. Each clock the block emits one 8-bit amplitude sample in offset-binary form, with code 128 at zero phase. The output frequency is the tuning word times the clock rate divided by 2^24. The digital-to-analog converter and the filtering that follows it are outside this block.

Top module: `dds_serial_synth`

## Requirements
- R1: While reset is low at a clock edge, the phase and the step register clear to zero and the sample output reads 128. After reset the output stays at 128 until the first word is committed.
- R2: The serial port captures `ser_data` on each falling edge of `ser_strobe` while `ser_update_en` is high. Bits arrive most significant first. The 24th captured bit completes the word, which becomes the phase step with no bit reordering.
- R3: If `ser_update_en` drops before 24 bits have been captured, the partial word is discarded and the bit count returns to zero. The step register keeps its previous value, and the next transfer again needs a full 24 bits.
- R4: Strobe falling edges after the 24th bit are ignored until `ser_update_en` is deasserted. The word that gets committed is the first 24 bits.
- R5: Take the clock edges after the final strobe falling edge of a word. The new step is first added to the phase on the fourth of these edges. On every edge before it the old step is added. The phase is neither reset nor reloaded.
- R6: The phase advances by the step on every clock edge and wraps modulo 2^24.
- R7: The sample produced on an edge comes from the phase held before that edge. Let a be phase bits [23:14]. The sample equals 128 + round(127 * sin(2*pi*a/1024)), to within one code. The code 0 never appears.
- R8: At the quadrant points the sample is exact. a = 0 and a = 512 give 128, a = 256 gives 255, and a = 768 gives 1.
- R9: Each completed word is committed exactly once. The step register changes only on a commit.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Synthesis clock |
| rst_n | input | 1 | Synchronous active-low reset of the synthesis domain |
| ser_strobe | input | 1 | Transfer strobe; data captured on its falling edge |
| ser_data | input | 1 | Serial tuning-word bit, most significant first |
| ser_update_en | input | 1 | Transfer window; low clears the bit count and blocks commits |
| sample_o | output | 8 | Offset-binary sine amplitude, one per clock |

## Verification
The assertions assume that `ser_update_en` rises at least two clock cycles before the first strobe falling edge. They also assume it stays high until at least four clock edges after the 24th falling edge, and that `ser_data` is steady at every strobe falling edge. The bench changes these inputs one time unit after a rising clock edge. It raises the enable two cycles ahead of each transfer and keeps it high for hundreds of cycles after the last bit. It only drops the enable early on purpose, for the partial-word case. There, no word is complete, so no commit can be pending.

// File: rtl/dds_pkg.sv
// dds_pkg: shared types and elaboration-time helpers for the serial synthesis core.
// Assumes callers pass small positive table sizes; all math is done in 64-bit integers.
package dds_pkg;

    // Folding controls derived from the two top table-address bits.
    typedef struct packed {
        logic negate;   // second half of the period: subtract from mid-scale
        logic mirror;   // second and fourth quarter: read the quarter table backwards
    } fold_t;

    // Rational sine approximation for angle pi*k/half_n, scaled to amp and rounded.
    // Uses 16x(1-x)/(5-4x(1-x)), exact at 0 and at a quarter turn.
    function automatic int tone_mag(input int k, input int half_n, input int amp);
        longint p;
        longint d;
        p = longint'(k) * longint'(half_n - k);
        d = 5 * longint'(half_n) * longint'(half_n) - 4 * p;
        return int'((32 * longint'(amp) * p + d) / (2 * d));
    endfunction

endpackage

// File: rtl/dds_serial_rx.sv
// dds_serial_rx: assembles one tuning word from a strobe-and-data serial link.
// Runs entirely on the strobe falling edge; a low update-enable asynchronously
// clears the bit count. Assumes data is steady at each strobe falling edge.
module dds_serial_rx #(
    parameter int WORD_W = 24
) (
    input  logic              strb_i,
    input  logic              data_i,
    input  logic              upd_en_i,
    output logic [WORD_W-1:0] shadow_o,
    output logic              done_o
);
    localparam int CNT_W = $clog2(WORD_W + 1);
    localparam logic [CNT_W-1:0] FULL = CNT_W'(WORD_W);

    logic [CNT_W-1:0]  bit_cnt;
    logic [WORD_W-1:0] shadow_q;

    // Count captured bits; saturate at a full word; clear whenever the window closes.
    always_ff @(negedge strb_i or negedge upd_en_i) begin
        if (!upd_en_i) begin
            bit_cnt <= '0;
        end else if (bit_cnt != FULL) begin
            bit_cnt <= bit_cnt + 1'b1;
        end
    end

    // Shift data in MSB first; freeze once the word is complete so the commit sees a stable value.
    always_ff @(negedge strb_i) begin
        if (upd_en_i && (bit_cnt != FULL)) begin
            shadow_q <= {shadow_q[WORD_W-2:0], data_i};
        end
    end

    assign done_o   = (bit_cnt == FULL);
    assign shadow_o = shadow_q;

    AST_SHADOW_FROZEN: assert property (@(negedge strb_i) disable iff (!upd_en_i)
        done_o |=> $stable(shadow_q)) else $error("shadow moved after completion"); // R4

    AST_COUNT_BOUND: assert property (@(negedge strb_i) disable iff (!upd_en_i)
        bit_cnt <= FULL) else $error("bit count beyond word size"); // R2

endmodule

// File: rtl/dds_commit_sync.sv
// dds_commit_sync: brings the word-complete level and the update-enable level into
// the synthesis clock domain and issues a one-cycle commit on the rising edge of
// the synchronized completion. Assumes both inputs stay steady for several clocks.
module dds_commit_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic done_a,
    input  logic upd_en_a,
    output logic commit_o
);
    logic [STAGES:0]   done_sh;
    logic [STAGES-1:0] en_sh;

    // Synchronizer chains; the completion chain has one extra flop for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            done_sh <= '0;
            en_sh   <= '0;
        end else begin
            done_sh <= {done_sh[STAGES-1:0], done_a};
            en_sh   <= {en_sh[STAGES-2:0], upd_en_a};
        end
    end

    // Commit once per completed word, and only while the window is still open.
    always_comb begin
        commit_o = done_sh[STAGES-1] & ~done_sh[STAGES] & en_sh[STAGES-1];
    end

    AST_COMMIT_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        commit_o |=> !commit_o) else $error("commit lasted more than one cycle"); // R9

endmodule

// File: rtl/dds_phase_acc.sv
// dds_phase_acc: holds the phase step and the running phase. A commit replaces the
// step without touching the phase. Assumes load_i is a single-cycle pulse.
module dds_phase_acc #(
    parameter int PHASE_W = 24
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               load_i,
    input  logic [PHASE_W-1:0] word_i,
    output logic [PHASE_W-1:0] phase_o
);
    logic [PHASE_W-1:0] step_q;
    logic [PHASE_W-1:0] phase_q;

    // Step register: loaded only on a commit.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            step_q <= '0;
        end else if (load_i) begin
            step_q <= word_i;
        end
    end

    // Phase register: free-running modulo-2^PHASE_W accumulation of the current step.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase_q <= '0;
        end else begin
            phase_q <= phase_q + step_q;
        end
    end

    assign phase_o = phase_q;

    AST_LOAD_KEEPS_PHASE: assert property (@(posedge clk) disable iff (!rst_n)
        load_i |=> phase_q == PHASE_W'($past(phase_q) + $past(step_q)))
        else $error("phase disturbed by a commit"); // R5

    AST_STEP_ONLY_ON_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        (step_q != $past(step_q)) |-> $past(load_i))
        else $error("step changed without a commit"); // R9

endmodule

// File: rtl/dds_sine_lut.sv
// dds_sine_lut: truncates the phase to a table address and produces a registered
// offset-binary sine sample from a quarter-period table with symmetry folding.
// The table holds QUARTER+1 entries so the peak code is stored directly.
module dds_sine_lut #(
    parameter int PHASE_W = 24,
    parameter int ADDR_W  = 10,
    parameter int OUT_W   = 8
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [PHASE_W-1:0] phase_i,
    output logic [OUT_W-1:0]   sample_o
);
    import dds_pkg::*;

    localparam int IDX_W   = ADDR_W - 2;
    localparam int QUARTER = 1 << IDX_W;
    localparam int MAG_W   = OUT_W - 1;
    localparam int AMP     = (1 << MAG_W) - 1;
    localparam logic [OUT_W-1:0] MID = OUT_W'(1 << MAG_W);

    logic [ADDR_W-1:0] addr;
    fold_t             fold;
    logic [IDX_W-1:0]  idx;
    logic [IDX_W:0]    fidx;
    logic [MAG_W-1:0]  mag;
    logic [MAG_W-1:0]  rom [QUARTER+1];

    // Quarter-period magnitude table, computed at elaboration.
    for (genvar k = 0; k <= QUARTER; k++) begin : g_rom
        assign rom[k] = MAG_W'(tone_mag(k, 2 * QUARTER, AMP));
    end

    // Address truncation and quadrant folding.
    always_comb begin
        addr        = phase_i[PHASE_W-1 -: ADDR_W];
        fold.negate = addr[ADDR_W-1];
        fold.mirror = addr[ADDR_W-2];
        idx         = addr[IDX_W-1:0];
        fidx        = fold.mirror ? ((IDX_W+1)'(QUARTER) - {1'b0, idx}) : {1'b0, idx};
        mag         = rom[fidx];
    end

    // Registered sample: mid-scale plus or minus the folded magnitude.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sample_o <= MID;
        end else if (fold.negate) begin
            sample_o <= MID - {1'b0, mag};
        end else begin
            sample_o <= MID + {1'b0, mag};
        end
    end

    AST_MIDSCALE_AT_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        $past(phase_i[PHASE_W-1 -: ADDR_W] == '0) |-> sample_o == MID)
        else $error("zero phase not at mid-scale"); // R8

    AST_NO_ZERO_CODE: assert property (@(posedge clk) disable iff (!rst_n)
        sample_o != '0) else $error("sample left the symmetric range"); // R7

endmodule

// File: rtl/dds_serial_synth.sv
// dds_serial_synth: top of the serially programmed sine synthesis core.
// Serial word assembly on the strobe, commit crossing, phase accumulation and
// sine lookup. Assumes update-enable frames each transfer and is held until commit.
module dds_serial_synth #(
    parameter int FTW_W       = 24,
    parameter int LUT_ADDR_W  = 10,
    parameter int SAMPLE_W    = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                ser_strobe,
    input  logic                ser_data,
    input  logic                ser_update_en,
    output logic [SAMPLE_W-1:0] sample_o
);
    logic [FTW_W-1:0] shadow_word;
    logic             word_done;
    logic             commit;
    logic [FTW_W-1:0] phase;

    dds_serial_rx #(.WORD_W(FTW_W)) u_rx (
        .strb_i   (ser_strobe),
        .data_i   (ser_data),
        .upd_en_i (ser_update_en),
        .shadow_o (shadow_word),
        .done_o   (word_done)
    );

    dds_commit_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .done_a   (word_done),
        .upd_en_a (ser_update_en),
        .commit_o (commit)
    );

    dds_phase_acc #(.PHASE_W(FTW_W)) u_acc (
        .clk     (clk),
        .rst_n   (rst_n),
        .load_i  (commit),
        .word_i  (shadow_word),
        .phase_o (phase)
    );

    dds_sine_lut #(.PHASE_W(FTW_W), .ADDR_W(LUT_ADDR_W), .OUT_W(SAMPLE_W)) u_lut (
        .clk      (clk),
        .rst_n    (rst_n),
        .phase_i  (phase),
        .sample_o (sample_o)
    );

endmodule

// File: tb/tb_dds_serial_synth.sv
module tb_dds_serial_synth;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       strb = 1'b0;
    logic       sdata = 1'b0;
    logic       upd = 1'b0;
    logic [7:0] sample;

    int    checks = 0;
    int    fails = 0;
    string cur_req = "R1";
    bit    finished = 1'b0;

    logic [23:0] m_phase = '0;
    logic [23:0] m_step = '0;
    logic [23:0] p_word = '0;
    bit          pend = 1'b0;
    int          p_cnt = 0;
    logic        rst_at_edge = 1'b0;
    int          e_val;
    bit          e_exact;
    int          seed_dummy;

    always #2 clk = ~clk;

    dds_serial_synth dut (
        .clk           (clk),
        .rst_n         (rst_n),
        .ser_strobe    (strb),
        .ser_data      (sdata),
        .ser_update_en (upd),
        .sample_o      (sample)
    );

    // Expected sample from R7: 128 + round(127*sin(2*pi*a/1024)), a = phase[23:14].
    function automatic int exp_sample(input logic [23:0] ph);
        real s;
        s = $sin(2.0 * 3.14159265358979 * real'(ph[23:14]) / 1024.0);
        return 128 + int'($floor(127.0 * s + 0.5));
    endfunction

    task automatic check_val(input int act, input int exp, input int tol, input string req);
        int diff;
        checks++;
        diff = act - exp;
        if (diff < 0) diff = -diff;
        if (diff > tol) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    always @(posedge clk) rst_at_edge <= rst_n;

    // Reference model: evaluated after each rising edge.
    always @(negedge clk) begin
        if (!finished) begin
            if (!rst_at_edge) begin
                check_val(int'(sample), 128, 0, "R1");
                m_phase = '0;
                m_step  = '0;
                pend    = 1'b0;
            end else begin
                e_val   = exp_sample(m_phase);
                e_exact = (m_phase[21:14] == 8'd0);
                if (m_phase == '0 && m_step == '0)
                    check_val(int'(sample), e_val, 0, "R1");
                else if (e_exact)
                    check_val(int'(sample), e_val, 0, "R8");
                else
                    check_val(int'(sample), e_val, 1, cur_req);
                m_phase = m_phase + m_step;   // R6 wrap through 24-bit width
                if (pend) begin
                    p_cnt++;
                    // p_cnt starts at -1: the first negedge after the last fall belongs to the edge before it (R5)
                    if (p_cnt == 3) begin
                        m_step = p_word;
                        pend   = 1'b0;
                    end
                end
            end
        end
    end

    task automatic cycles(input int n);
        for (int i = 0; i < n; i++) @(posedge clk);
        #1;
    endtask

    // Shift nbits of w MSB first; optionally add extra strobes right after the word.
    task automatic send_bits(input logic [23:0] w, input int nbits, input int extra);
        for (int b = 0; b < nbits; b++) begin
            @(posedge clk); #1;
            sdata = w[23-b];
            strb  = 1'b1;
            @(posedge clk); #1;
            strb  = 1'b0;
        end
        if (nbits == 24) begin
            p_word = w;
            p_cnt  = -1;
            pend   = 1'b1;
        end
        for (int x = 0; x < extra; x++) begin
            @(posedge clk); #1;
            sdata = ~sdata;
            strb  = 1'b1;
            @(posedge clk); #1;
            strb  = 1'b0;
        end
    endtask

    task automatic load_word(input logic [23:0] w, input int run, input int extra);
        @(posedge clk); #1;
        upd = 1'b1;
        cycles(2);
        send_bits(w, 24, extra);
        cycles(run);
        upd = 1'b0;
        cycles(4);
    endtask

    task automatic finish_run();
        finished = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    endtask

    initial begin
        #800000;
        fails++;
        $display("FAIL watchdog actual=timeout expected=completion");
        finish_run();
    end

    initial begin
        seed_dummy = $urandom(32'd4242);
        // R1: reset state and mid-scale hold before any word
        cycles(4);
        rst_n = 1'b1;
        cycles(20);

        // R2 and R8: quarter-turn step from zero phase hits exact quadrant points
        cur_req = "R2";
        load_word(24'h400000, 200, 0);

        // R1: reset mid-run returns to mid-scale and stays there
        cur_req = "R1";
        rst_n = 1'b0;
        cycles(3);
        rst_n = 1'b1;
        cycles(20);

        // R8: half-rate step alternates 128 and 128
        cur_req = "R8";
        load_word(24'h800000, 100, 0);

        // R6: maximum step, phase wraps backward every edge
        cur_req = "R6";
        load_word(24'hFFFFFF, 300, 0);

        // R3: partial word discarded, step unchanged, next word needs full 24 bits
        cur_req = "R3";
        @(posedge clk); #1;
        upd = 1'b1;
        cycles(2);
        send_bits(24'h123456, 10, 0);
        @(posedge clk); #1;
        upd = 1'b0;
        cycles(150);
        load_word(24'h0A0A0A, 300, 0);

        // R4: extra strobes right after the 24th bit do not alter the committed word
        cur_req = "R4";
        load_word(24'h031337, 300, 3);

        // R5: frequency change keeps phase continuous; checks cover the switch window
        cur_req = "R5";
        load_word(24'h000400, 100, 0);
        load_word(24'h0F1234, 300, 0);

        // R7 and R9: random words, each committed once
        cur_req = "R7";
        for (int n = 0; n < 10; n++) begin
            load_word(24'($urandom()), 250, n % 2);
        end
        cur_req = "R9";
        load_word(24'($urandom()), 250, 0);
        cycles(10);

        finish_run();
    end
endmodule